// File: doc/BRIEF.md
# Private Interrupt Group Resolver and SGI Admission Gate

This block sits beside the per-core storage of private interrupt configuration in an interrupt controller. For every private interrupt ID it turns the stored group bit and group-modifier bit into one of three security groups. The global security-disable input changes how those two bits are read. Any ID can be queried, and the resolved group comes back combinationally.

The block also judges incoming software-generated interrupt (SGI) requests. A request carries an SGI number, the group the sender asked for, and a flag that marks a non-secure sender. The gate first downgrades a secure-group-1 request aimed at a group-0 interrupt. It then drops group-0 requests that do not match, and it holds non-secure senders to the per-SGI access level. An accepted request produces a one-cycle set-pending strobe with the SGI number, and the storage uses that strobe to set the pending bit. A third, purely combinational path reports whether this core may be picked as the target of a 1-of-N distributed interrupt of a given group.

Group codes used on all group ports: 2'b00 secure group 0, 2'b01 secure group 1, 2'b10 non-secure group 1, 2'b11 no group.

Top module: `pirq_group_ctrl`

## Requirements
- R1: When `sec_dis` is 1, an ID whose group bit is 0 resolves to 2'b00 and one whose group bit is 1 resolves to 2'b10, whatever its modifier bit; code 2'b01 never appears on `query_grp`.
- R2: When `sec_dis` is 0, the bit pair {modifier, group} of the ID given by `query_id` resolves combinationally on `query_grp`: 00 gives 2'b00, 01 gives 2'b10, 10 gives 2'b01, 11 gives 2'b10.
- R3: A request for group 2'b01 aimed at an SGI that resolves to 2'b00 is handled as a group 2'b00 request, so a secure sender gets it accepted.
- R4: A request for group 2'b00 aimed at an SGI that does not resolve to 2'b00 is dropped.
- R5: With `sec_dis` at 0, a request with `req_ns` at 1 is accepted for an SGI that resolves to 2'b00 only when its access level `nsa_level[2*i+1:2*i]` is at least 1. For an SGI that resolves to 2'b01 the level must be at least 2. Secure senders and SGIs that resolve to non-secure group 1 are not checked against the level.
- R6: An accepted request raises `set_pend` for exactly one cycle, on the clock edge after the cycle in which `req_valid` was sampled high, with `set_id` equal to the requested SGI number. Any other request leaves `set_pend` low. A request for a group other than the resolved one is accepted when R3 to R5 allow it.
- R7: `eligible` is 0 while `asleep` is 1.
- R8: With `asleep` at 0, `eligible` is 1 exactly when `grp_en[sel_grp]` is 1 and `grp_dis[sel_grp]` is 0. Bit k of both vectors belongs to group code k. A `sel_grp` of 2'b11 gives 0.
- R9: A request with `req_id` of 16 or more, or with `req_grp` equal to 2'b11, is ignored: `set_pend` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_dis | input | 1 | Global security disable |
| grp_bits | input | NUM_IDS | Group bit per private ID |
| mod_bits | input | NUM_IDS | Group-modifier bit per private ID |
| nsa_level | input | 2*NUM_SGI | Non-secure access level per SGI, two bits each |
| query_id | input | ID_W | ID whose group is looked up |
| query_grp | output | 2 | Resolved group of `query_id` |
| req_valid | input | 1 | SGI request present this cycle |
| req_id | input | ID_W | Requested SGI number |
| req_grp | input | 2 | Group the sender asked for |
| req_ns | input | 1 | Sender is non-secure |
| set_pend | output | 1 | One-cycle strobe: set the pending bit of `set_id` |
| set_id | output | SGI_W | SGI number for `set_pend` |
| asleep | input | 1 | Core is in its low-power state |
| grp_en | input | 3 | Global enable per group code |
| grp_dis | input | 3 | 1-of-N disable per group code |
| sel_grp | input | 2 | Group of the distributed interrupt being placed |
| eligible | output | 1 | Core may be chosen for the 1-of-N interrupt |

## Verification
The assertions assume that the configuration bits, the access levels and the security-disable setting stay steady around a request. Each acceptance property reads them at the edge that samples `req_valid` and expects the strobe one edge later. The assertions also assume `req_valid` is a clean level at each edge. The bench keeps to this by changing every input only on the falling clock edge and holding each request for exactly one cycle. It reads the strobe at the next falling edge and then drops the request. The eligibility path is combinational, so its properties hold at any edge where the inputs are settled, and the bench always meets that.

// File: rtl/pirq_grp_pkg.sv
package pirq_grp_pkg;

  typedef enum logic [1:0] {
    GRP_S0   = 2'b00,
    GRP_S1   = 2'b01,
    GRP_NS1  = 2'b10,
    GRP_NONE = 2'b11
  } grp_e;

  // Resolve a private ID's group from its two configuration bits.
  function automatic grp_e resolve_grp(input logic sec_dis,
                                       input logic gbit,
                                       input logic mbit);
    grp_e r;
    if (sec_dis) begin
      r = gbit ? GRP_NS1 : GRP_S0;
    end else begin
      case ({mbit, gbit})
        2'b00:   r = GRP_S0;
        2'b10:   r = GRP_S1;
        default: r = GRP_NS1;
      endcase
    end
    return r;
  endfunction

  // Downgrade a secure group 1 request that targets a group 0 interrupt.
  function automatic grp_e eff_req_grp(input grp_e res, input grp_e req);
    return (res == GRP_S0 && req == GRP_S1) ? GRP_S0 : req;
  endfunction

  // Acceptance decision for one SGI request, given its resolved group.
  function automatic logic admit_sgi(input grp_e       res,
                                     input grp_e       req,
                                     input logic       ns,
                                     input logic       sec_dis,
                                     input logic [1:0] lvl);
    grp_e eff;
    logic ok;
    eff = eff_req_grp(res, req);
    ok  = (req != GRP_NONE);
    if (eff == GRP_S0 && res != GRP_S0) ok = 1'b0;
    if (ns && !sec_dis) begin
      if (res == GRP_S0 && lvl < 2'd1) ok = 1'b0;
      if (res == GRP_S1 && lvl < 2'd2) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/pirq_grp_resolver.sv
module pirq_grp_resolver
  import pirq_grp_pkg::*;
#(
  parameter int NUM_IDS = 32
) (
  input  logic                    sec_dis,
  input  logic [NUM_IDS-1:0]      grp_bits,
  input  logic [NUM_IDS-1:0]      mod_bits,
  output logic [NUM_IDS-1:0][1:0] id_grp
);

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
    assign id_grp[i] = resolve_grp(sec_dis, grp_bits[i], mod_bits[i]);
  end

endmodule

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate
  import pirq_grp_pkg::*;
#(
  parameter int NUM_IDS = 32,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_IDS),
  localparam int SGI_W = $clog2(NUM_SGI)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_dis,
  input  logic [NUM_IDS-1:0][1:0] id_grp,
  input  logic [NUM_SGI-1:0][1:0] nsa_arr,
  input  logic                    req_valid,
  input  logic [ID_W-1:0]         req_id,
  input  logic [1:0]              req_grp,
  input  logic                    req_ns,
  output logic [1:0]              req_res_grp,
  output logic [1:0]              req_lvl,
  output logic                    req_in_range,
  output logic                    set_pend,
  output logic [SGI_W-1:0]        set_id
);

  logic [SGI_W-1:0] sgi_idx;
  logic             admit;

  assign sgi_idx      = req_id[SGI_W-1:0];
  assign req_in_range = (req_id[ID_W-1:SGI_W] == '0);
  assign req_res_grp  = id_grp[req_id];
  assign req_lvl      = nsa_arr[sgi_idx];
  assign admit        = req_valid && req_in_range &&
                        admit_sgi(grp_e'(req_res_grp), grp_e'(req_grp),
                                  req_ns, sec_dis, req_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pend <= 1'b0;
      set_id   <= '0;
    end else begin
      set_pend <= admit;
      if (admit) set_id <= sgi_idx;
    end
  end

endmodule

// File: rtl/pirq_target_elig.sv
module pirq_target_elig
  import pirq_grp_pkg::*;
(
  input  logic       asleep,
  input  logic [2:0] grp_en,
  input  logic [2:0] grp_dis,
  input  logic [1:0] sel_grp,
  output logic       eligible
);

  logic en_hit;
  logic dis_hit;

  always_comb begin
    en_hit  = 1'b0;
    dis_hit = 1'b0;
    case (grp_e'(sel_grp))
      GRP_S0:  begin en_hit = grp_en[0]; dis_hit = grp_dis[0]; end
      GRP_S1:  begin en_hit = grp_en[1]; dis_hit = grp_dis[1]; end
      GRP_NS1: begin en_hit = grp_en[2]; dis_hit = grp_dis[2]; end
      default: begin en_hit = 1'b0;      dis_hit = 1'b1;      end
    endcase
  end

  assign eligible = !asleep && en_hit && !dis_hit;

endmodule

// File: rtl/pirq_group_ctrl.sv
module pirq_group_ctrl
  import pirq_grp_pkg::*;
#(
  parameter int NUM_IDS = 32,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_IDS),
  localparam int SGI_W = $clog2(NUM_SGI)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_dis,
  input  logic [NUM_IDS-1:0]   grp_bits,
  input  logic [NUM_IDS-1:0]   mod_bits,
  input  logic [2*NUM_SGI-1:0] nsa_level,
  input  logic [ID_W-1:0]      query_id,
  output logic [1:0]           query_grp,
  input  logic                 req_valid,
  input  logic [ID_W-1:0]      req_id,
  input  logic [1:0]           req_grp,
  input  logic                 req_ns,
  output logic                 set_pend,
  output logic [SGI_W-1:0]     set_id,
  input  logic                 asleep,
  input  logic [2:0]           grp_en,
  input  logic [2:0]           grp_dis,
  input  logic [1:0]           sel_grp,
  output logic                 eligible
);

  logic [NUM_IDS-1:0][1:0] id_grp;
  logic [NUM_SGI-1:0][1:0] nsa_arr;
  logic [1:0]              req_res_grp;
  logic [1:0]              req_lvl;
  logic                    req_in_range;

  assign nsa_arr   = nsa_level;
  assign query_grp = id_grp[query_id];

  pirq_grp_resolver #(.NUM_IDS(NUM_IDS)) u_res (
    .sec_dis  (sec_dis),
    .grp_bits (grp_bits),
    .mod_bits (mod_bits),
    .id_grp   (id_grp)
  );

  pirq_sgi_gate #(.NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_dis      (sec_dis),
    .id_grp       (id_grp),
    .nsa_arr      (nsa_arr),
    .req_valid    (req_valid),
    .req_id       (req_id),
    .req_grp      (req_grp),
    .req_ns       (req_ns),
    .req_res_grp  (req_res_grp),
    .req_lvl      (req_lvl),
    .req_in_range (req_in_range),
    .set_pend     (set_pend),
    .set_id       (set_id)
  );

  pirq_target_elig u_elig (
    .asleep   (asleep),
    .grp_en   (grp_en),
    .grp_dis  (grp_dis),
    .sel_grp  (sel_grp),
    .eligible (eligible)
  );

endmodule

// File: rtl/pirq_group_ctrl_chk.sv
module pirq_group_ctrl_chk #(
  parameter int NUM_IDS = 32,
  parameter int NUM_SGI = 16,
  localparam int ID_W  = $clog2(NUM_IDS),
  localparam int SGI_W = $clog2(NUM_SGI)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_dis,
  input logic [NUM_IDS-1:0] grp_bits,
  input logic [NUM_IDS-1:0] mod_bits,
  input logic [ID_W-1:0]    query_id,
  input logic [1:0]         query_grp,
  input logic               req_valid,
  input logic [ID_W-1:0]    req_id,
  input logic [1:0]         req_grp,
  input logic               req_ns,
  input logic [1:0]         req_res_grp,
  input logic [1:0]         req_lvl,
  input logic               req_in_range,
  input logic               set_pend,
  input logic [SGI_W-1:0]   set_id,
  input logic               asleep,
  input logic [2:0]         grp_dis,
  input logic [1:0]         sel_grp,
  input logic               eligible
);

  a_r1_no_secure_g1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_dis |-> query_grp != 2'b01);

  a_r2_modifier_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_dis && mod_bits[query_id] && !grp_bits[query_id]) |-> query_grp == 2'b01);

  a_r3_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_range && !req_ns && req_res_grp == 2'b00 && req_grp == 2'b01)
      |=> set_pend);

  a_r4_g0_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grp == 2'b00 && req_res_grp != 2'b00) |=> !set_pend);

  a_r5_ns_level: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ns && !sec_dis &&
     ((req_res_grp == 2'b00 && req_lvl == 2'd0) ||
      (req_res_grp == 2'b01 && req_lvl < 2'd2))) |=> !set_pend);

  a_r6_strobe_origin: assert property (@(posedge clk) disable iff (!rst_n)
    set_pend |-> ($past(req_valid) && set_id == $past(req_id[SGI_W-1:0])));

  a_r7_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !eligible);

  a_r8_disabled_group: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_grp == 2'b00 && grp_dis[0]) || (sel_grp == 2'b01 && grp_dis[1]) ||
     (sel_grp == 2'b10 && grp_dis[2]) || sel_grp == 2'b11) |-> !eligible);

  a_r9_ignored_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_id[ID_W-1:SGI_W] != '0 || req_grp == 2'b11)) |=> !set_pend);

endmodule

bind pirq_group_ctrl pirq_group_ctrl_chk #(.NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_dis      (sec_dis),
  .grp_bits     (grp_bits),
  .mod_bits     (mod_bits),
  .query_id     (query_id),
  .query_grp    (query_grp),
  .req_valid    (req_valid),
  .req_id       (req_id),
  .req_grp      (req_grp),
  .req_ns       (req_ns),
  .req_res_grp  (req_res_grp),
  .req_lvl      (req_lvl),
  .req_in_range (req_in_range),
  .set_pend     (set_pend),
  .set_id       (set_id),
  .asleep       (asleep),
  .grp_dis      (grp_dis),
  .sel_grp      (sel_grp),
  .eligible     (eligible)
);

// File: tb/pirq_group_ctrl_tb.sv
`timescale 1ns/1ps
module pirq_group_ctrl_tb;

  localparam int NUM_IDS = 32;
  localparam int NUM_SGI = 16;
  localparam int ID_W    = 5;
  localparam int SGI_W   = 4;

  // {sec_dis, grp, mod, nsa[1:0], req_grp[1:0], ns, expect_accept}
  localparam logic [8:0] VEC [16] = '{
    9'b100000011, 9'b000000010, 9'b000010011, 9'b001010110,
    9'b001100111, 9'b001000101, 9'b010000000, 9'b000000101,
    9'b000000110, 9'b011001011, 9'b101000101, 9'b111000000,
    9'b001000000, 9'b001001001, 9'b011001100, 9'b001110111
  };
  // expected group for index {sec_dis, mod, grp}
  localparam logic [1:0] RES_EXP [8] = '{
    2'b00, 2'b10, 2'b01, 2'b10, 2'b00, 2'b10, 2'b00, 2'b10
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sec_dis = 1'b0;
  logic [NUM_IDS-1:0]   grp_bits = '0;
  logic [NUM_IDS-1:0]   mod_bits = '0;
  logic [2*NUM_SGI-1:0] nsa_level = '0;
  logic [ID_W-1:0]      query_id = '0;
  logic [1:0]           query_grp;
  logic                 req_valid = 1'b0;
  logic [ID_W-1:0]      req_id = '0;
  logic [1:0]           req_grp = '0;
  logic                 req_ns = 1'b0;
  logic                 set_pend;
  logic [SGI_W-1:0]     set_id;
  logic                 asleep = 1'b0;
  logic [2:0]           grp_en = 3'b111;
  logic [2:0]           grp_dis = 3'b000;
  logic [1:0]           sel_grp = 2'b10;
  logic                 eligible;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pirq_group_ctrl #(.NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_dis(sec_dis), .grp_bits(grp_bits),
    .mod_bits(mod_bits), .nsa_level(nsa_level), .query_id(query_id),
    .query_grp(query_grp), .req_valid(req_valid), .req_id(req_id),
    .req_grp(req_grp), .req_ns(req_ns), .set_pend(set_pend), .set_id(set_id),
    .asleep(asleep), .grp_en(grp_en), .grp_dis(grp_dis), .sel_grp(sel_grp),
    .eligible(eligible)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Put one ID's bits in place and give every other ID the opposite bits.
  task automatic setup_id(input int id, input logic g, input logic m, input logic [1:0] lvl);
    grp_bits = {NUM_IDS{~g}};
    mod_bits = {NUM_IDS{~m}};
    nsa_level = {NUM_SGI{~lvl}};
    grp_bits[id] = g;
    mod_bits[id] = m;
    nsa_level[2*id +: 2] = lvl;
  endtask

  // Request held for one cycle; strobe read at the next falling edge.
  task automatic send(input int id, input logic [1:0] rg, input logic ns);
    req_valid = 1'b1;
    req_id = ID_W'(id);
    req_grp = rg;
    req_ns = ns;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset set_pend", int'(set_pend), 0);
    check("R6 reset set_id", int'(set_id), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Admission table
    for (int k = 0; k < 16; k++) begin
      sec_dis = VEC[k][8];
      setup_id(k, VEC[k][7], VEC[k][6], VEC[k][5:4]);
      @(negedge clk);
      send(k, VEC[k][3:2], VEC[k][1]);
      check($sformatf("R3 R4 R5 R9 vector %0d accept", k), int'(set_pend), int'(VEC[k][0]));
      if (VEC[k][0]) check($sformatf("R6 vector %0d id", k), int'(set_id), k);
      @(negedge clk);
      check($sformatf("R6 vector %0d strobe one cycle", k), int'(set_pend), 0);
    end

    // Group resolution for both settings
    for (int s = 0; s < 8; s++) begin
      sec_dis = s[2];
      setup_id(7, s[0], s[1], 2'b00);
      query_id = 5'd7;
      #1;
      check($sformatf("%s resolve code %0d", s[2] ? "R1" : "R2", s), int'(query_grp), int'(RES_EXP[s]));
    end
    sec_dis = 1'b0;
    setup_id(25, 1'b0, 1'b1, 2'b00);
    query_id = 5'd25;
    #1;
    check("R2 resolve upper id", int'(query_grp), 1);

    // IDs of 16 and above are ignored
    @(negedge clk);
    setup_id(20, 1'b1, 1'b1, 2'b11);
    @(negedge clk);
    send(20, 2'b10, 1'b0);
    check("R9 high id ignored", int'(set_pend), 0);
    setup_id(4, 1'b1, 1'b1, 2'b11);
    @(negedge clk);
    send(4, 2'b10, 1'b0);
    check("R6 accept after ignored", int'(set_pend), 1);
    check("R6 accept id", int'(set_id), 4);

    // 1-of-N eligibility
    @(negedge clk);
    asleep = 1'b1; sel_grp = 2'b10; #1;
    check("R7 asleep", int'(eligible), 0);
    asleep = 1'b0; #1;
    check("R8 awake enabled", int'(eligible), 1);
    grp_en = 3'b101; sel_grp = 2'b01; #1;
    check("R8 group not enabled", int'(eligible), 0);
    grp_en = 3'b111; grp_dis = 3'b100; sel_grp = 2'b10; #1;
    check("R8 group disabled", int'(eligible), 0);
    sel_grp = 2'b00; #1;
    check("R8 other group bit no effect", int'(eligible), 1);
    grp_dis = 3'b001; #1;
    check("R8 group0 disabled", int'(eligible), 0);
    grp_dis = 3'b000; sel_grp = 2'b11; #1;
    check("R8 no group code", int'(eligible), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule